// File: doc/BRIEF.md
# Dual-Path Configuration Register Bank

This block holds a small set of 64-bit configuration and status registers that two agents reach independently. A scan-style port addresses the registers by byte address, and the register index is that address divided by eight. A memory-mapped port also uses byte addresses, but its index window starts ten registers higher. Both ports decode onto one shared index space. Every access moves a full aligned 64-bit word, and the word is carried as one big-endian quantity with no byte lanes.

Several registers accept more than one kind of write. A fault register can be written directly or through alias indices that AND or OR the data into it. A control register can be written directly or through alias indices that set or clear individual bits. A base-address register keeps only the bits its mask allows plus an enable bit in bit 0. Only the scan port may write it. Whenever its stored value changes, the block pulses a window-change strobe so that external logic can move the mapped address window. A status register mirrors the incoming interrupt source levels and cannot be written. Any refused or unimplemented access pulses a shared error output.

Top module: `dual_path_cfg_regs`

## Requirements
- R1: After reset every register reads zero, except the base-address register (index 0x0A), which reads `(BAR_RESET & BAR_MASK) | 1`; `win_en` is 1 and `err_pulse`, `win_changed`, `scan_rvalid` and `mm_rvalid` are 0.
- R2: The scan port index is `scan_addr >> 3` and the memory-mapped port index is `(mm_addr >> 3) + 0x0A`. An access whose address has nonzero bits [2:0] is refused: it changes nothing, a read returns all ones, and `err_pulse` rises.
- R3: Writing index 0x00 loads the fault register. Writing index 0x01 ANDs the data into it, and writing index 0x02 ORs the data into it.
- R4: Writing index 0x0E loads the control register. Writing index 0x12 sets the written bits, and writing index 0x13 clears them.
- R5: A scan write to index 0x0A stores `data & (BAR_MASK | 1)`. A memory-mapped write to index 0x0A is refused, leaves the register unchanged and raises `err_pulse`.
- R6: Index 0x0B keeps only bits 49 down to 32 of the written data; all other bits read zero.
- R7: A read of an unimplemented or write-only index returns all ones and raises `err_pulse`. The write-only indices are 0x01, 0x02, 0x12 and 0x13. A write to an unimplemented index changes nothing and raises `err_pulse`.
- R8: Index 0x15 reads `irq_lvl` in bits [NUM_SRC-1:0], sampled one cycle earlier, with zeros above. Writes to it are refused and raise `err_pulse`.
- R9: Read data and its `rvalid` strobe appear on the requesting port one clock after the request is sampled. `err_pulse` appears in that same cycle and lasts one cycle.
- R10: `win_changed` pulses for one cycle, one clock after a base-address write that changes the stored value. A write that stores the same value gives no pulse.
- R11: When both ports request in the same cycle, the scan access is performed. The memory-mapped access is refused: it writes nothing, a read returns all ones, and `err_pulse` rises.
- R12: Indices 0x06, 0x07, 0x0F and 0x14 are plain 64-bit read/write registers that keep every written bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_valid | input | 1 | Scan port request this cycle |
| scan_write | input | 1 | Scan request is a write (1) or a read (0) |
| scan_addr | input | SCAN_AW | Scan port byte address |
| scan_wdata | input | 64 | Scan write data |
| scan_rvalid | output | 1 | Scan read data valid |
| scan_rdata | output | 64 | Scan read data |
| mm_valid | input | 1 | Memory-mapped port request this cycle |
| mm_write | input | 1 | Memory-mapped request is a write (1) or a read (0) |
| mm_addr | input | MM_AW | Memory-mapped byte address |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_rvalid | output | 1 | Memory-mapped read data valid |
| mm_rdata | output | 64 | Memory-mapped read data |
| irq_lvl | input | NUM_SRC | Interrupt source levels mirrored into the status register |
| err_pulse | output | 1 | One-cycle pulse on a refused or unimplemented access |
| win_changed | output | 1 | One-cycle pulse after the base-address register changes |
| win_base | output | 64 | Masked address held in the base-address register |
| win_en | output | 1 | Enable bit of the base-address register |

## Verification
The assertions assume that each port raises `valid` for single-cycle requests, and that reset is held for at least two clocks before the first request, so that the base register's history starts from its reset value. They also assume that a request's write flag and address are meaningful whenever `valid` is high. The bench drives every request for exactly one cycle, starting just after a rising edge, and releases reset only after several cycles. It issues simultaneous requests only in the collision cases, where the expected outcome is the refusal of the memory-mapped request.

// File: rtl/cfgrf_pkg.sv
// Package: shared index constants and access-legality functions for the
// dual-path configuration register bank. Assumes a 6-bit index space.
package cfgrf_pkg;

    localparam int IDX_W     = 6;
    localparam int WORD_W    = 64;
    localparam int NUM_PLAIN = 4;

    localparam logic [IDX_W-1:0] IDX_FAULT     = 6'h00;
    localparam logic [IDX_W-1:0] IDX_FAULT_AND = 6'h01;
    localparam logic [IDX_W-1:0] IDX_FAULT_OR  = 6'h02;
    localparam logic [IDX_W-1:0] IDX_BASE      = 6'h0A;
    localparam logic [IDX_W-1:0] IDX_SBASE     = 6'h0B;
    localparam logic [IDX_W-1:0] IDX_CTRL      = 6'h0E;
    localparam logic [IDX_W-1:0] IDX_CTRL_SET  = 6'h12;
    localparam logic [IDX_W-1:0] IDX_CTRL_CLR  = 6'h13;
    localparam logic [IDX_W-1:0] IDX_STAT      = 6'h15;

    // Offset added to the memory-mapped word index.
    localparam logic [IDX_W-1:0] MM_IDX_OFF    = 6'h0A;

    // Bits kept by the secondary base register (49..32).
    localparam logic [WORD_W-1:0] SBASE_KEEP   = 64'h0003_ffff_0000_0000;

    // Indices of the plain storage registers.
    localparam logic [IDX_W-1:0] PLAIN_IDX [NUM_PLAIN] = '{6'h06, 6'h07, 6'h0F, 6'h14};

    // True when idx names a plain storage register.
    function automatic logic is_plain(input logic [IDX_W-1:0] idx);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_PLAIN; i++) begin
            if (idx == PLAIN_IDX[i]) hit = 1'b1;
        end
        return hit;
    endfunction

    // True when a read of idx returns register content.
    function automatic logic rd_legal(input logic [IDX_W-1:0] idx);
        return is_plain(idx) || idx == IDX_FAULT || idx == IDX_BASE ||
               idx == IDX_SBASE || idx == IDX_CTRL || idx == IDX_STAT;
    endfunction

    // True when a write of idx from the given path is accepted.
    function automatic logic wr_legal(input logic [IDX_W-1:0] idx, input logic from_mm);
        return is_plain(idx) || idx == IDX_FAULT || idx == IDX_FAULT_AND ||
               idx == IDX_FAULT_OR || idx == IDX_SBASE || idx == IDX_CTRL ||
               idx == IDX_CTRL_SET || idx == IDX_CTRL_CLR ||
               (idx == IDX_BASE && !from_mm);
    endfunction

endpackage

// File: rtl/cfgrf_addr_decode.sv
// Address decoder: turns a byte address into a register index by dropping
// the three byte-lane bits and adding a path offset; flags misalignment.
// Assumes AW - 3 <= IDX_W so the word index fits.
module cfgrf_addr_decode
    import cfgrf_pkg::*;
#(
    parameter int               AW  = 8,
    parameter logic [IDX_W-1:0] OFF = '0
) (
    input  logic [AW-1:0]    addr,
    output logic [IDX_W-1:0] idx,
    output logic             aligned
);

    localparam int WORD_AW = AW - 3;

    // Index computation and full-word alignment check.
    always_comb begin
        idx     = IDX_W'(addr[AW-1:3]) + OFF;
        aligned = (addr[2:0] == 3'b000);
    end

    if (WORD_AW > IDX_W) begin : g_bad_width
        initial $error("cfgrf_addr_decode: address too wide for index");
    end

endmodule

// File: rtl/cfgrf_store.sv
// Register storage: holds the fault, control, base, secondary base, status
// and plain registers, and applies direct and aliased writes. Assumes
// wr_en only when the write was judged legal by the caller.
module cfgrf_store
    import cfgrf_pkg::*;
#(
    parameter int                NUM_SRC   = 5,
    parameter logic [WORD_W-1:0] BAR_MASK  = 64'h0003_ffff_fff0_0000,
    parameter logic [WORD_W-1:0] BAR_RESET = 64'h0000_0006_0300_0000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic [NUM_SRC-1:0]                irq_lvl,
    output logic [WORD_W-1:0]                 fault_q,
    output logic [WORD_W-1:0]                 ctrl_q,
    output logic [WORD_W-1:0]                 base_q,
    output logic [WORD_W-1:0]                 sbase_q,
    output logic [WORD_W-1:0]                 stat_q,
    output logic [NUM_PLAIN-1:0][WORD_W-1:0]  plain_q,
    output logic                              win_chg
);

    localparam logic [WORD_W-1:0] BASE_KEEP = BAR_MASK | 64'h1;
    localparam logic [WORD_W-1:0] BASE_INIT = (BAR_RESET & BAR_MASK) | 64'h1;

    logic [WORD_W-1:0] base_next;

    // Candidate base value after masking.
    always_comb base_next = wr_data & BASE_KEEP;

    // Fault register with direct, AND and OR writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_FAULT:     fault_q <= wr_data;
                IDX_FAULT_AND: fault_q <= fault_q & wr_data;
                IDX_FAULT_OR:  fault_q <= fault_q | wr_data;
                default:       fault_q <= fault_q;
            endcase
        end
    end

    // Control register with direct, set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_CTRL:     ctrl_q <= wr_data;
                IDX_CTRL_SET: ctrl_q <= ctrl_q | wr_data;
                IDX_CTRL_CLR: ctrl_q <= ctrl_q & ~wr_data;
                default:      ctrl_q <= ctrl_q;
            endcase
        end
    end

    // Base register and its change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= BASE_INIT;
            win_chg <= 1'b0;
        end else begin
            win_chg <= 1'b0;
            if (wr_en && wr_idx == IDX_BASE) begin
                base_q  <= base_next;
                win_chg <= (base_next != base_q);
            end
        end
    end

    // Secondary base register, upper address bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbase_q <= '0;
        end else if (wr_en && wr_idx == IDX_SBASE) begin
            sbase_q <= wr_data & SBASE_KEEP;
        end
    end

    // Status register mirrors the source levels each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= {{(WORD_W-NUM_SRC){1'b0}}, irq_lvl};
        end
    end

    // Plain storage registers, one per listed index.
    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                plain_q[g] <= '0;
            end else if (wr_en && wr_idx == PLAIN_IDX[g]) begin
                plain_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/cfgrf_read_mux.sv
// Read multiplexer: selects the register named by idx, or all ones when
// the index has no readable register. Purely combinational.
module cfgrf_read_mux
    import cfgrf_pkg::*;
(
    input  logic [IDX_W-1:0]                  idx,
    input  logic [WORD_W-1:0]                 fault_q,
    input  logic [WORD_W-1:0]                 ctrl_q,
    input  logic [WORD_W-1:0]                 base_q,
    input  logic [WORD_W-1:0]                 sbase_q,
    input  logic [WORD_W-1:0]                 stat_q,
    input  logic [NUM_PLAIN-1:0][WORD_W-1:0]  plain_q,
    output logic [WORD_W-1:0]                 rd_data,
    output logic                              rd_hit
);

    // Register selection by index.
    always_comb begin
        rd_hit  = rd_legal(idx);
        rd_data = '1;
        case (idx)
            IDX_FAULT: rd_data = fault_q;
            IDX_CTRL:  rd_data = ctrl_q;
            IDX_BASE:  rd_data = base_q;
            IDX_SBASE: rd_data = sbase_q;
            IDX_STAT:  rd_data = stat_q;
            default: begin
                for (int i = 0; i < NUM_PLAIN; i++) begin
                    if (idx == PLAIN_IDX[i]) rd_data = plain_q[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/dual_path_cfg_regs.sv
// Top: two request ports (scan and memory-mapped) share one register bank.
// The scan port wins a same-cycle collision; the memory-mapped request is
// then refused. Assumes single-cycle requests and full 8-byte words.
module dual_path_cfg_regs
    import cfgrf_pkg::*;
#(
    parameter int          SCAN_AW   = 8,
    parameter int          MM_AW     = 8,
    parameter int          NUM_SRC   = 5,
    parameter logic [63:0] BAR_MASK  = 64'h0003_ffff_fff0_0000,
    parameter logic [63:0] BAR_RESET = 64'h0000_0006_0300_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_valid,
    input  logic               scan_write,
    input  logic [SCAN_AW-1:0] scan_addr,
    input  logic [63:0]        scan_wdata,
    output logic               scan_rvalid,
    output logic [63:0]        scan_rdata,
    input  logic               mm_valid,
    input  logic               mm_write,
    input  logic [MM_AW-1:0]   mm_addr,
    input  logic [63:0]        mm_wdata,
    output logic               mm_rvalid,
    output logic [63:0]        mm_rdata,
    input  logic [NUM_SRC-1:0] irq_lvl,
    output logic               err_pulse,
    output logic               win_changed,
    output logic [63:0]        win_base,
    output logic               win_en
);

    logic [IDX_W-1:0] s_idx, m_idx, acc_idx;
    logic             s_al, m_al, acc_al;
    logic             acc_valid, acc_mm, acc_write;
    logic [63:0]      acc_wdata;
    logic             mm_blocked, ok_rd, ok_wr, wr_en, err_d;
    logic [63:0]      rd_data, rd_word;
    logic             rd_hit;

    logic [63:0]                     fault_q, ctrl_q, base_q, sbase_q, stat_q;
    logic [NUM_PLAIN-1:0][63:0]      plain_q;

    cfgrf_addr_decode #(.AW(SCAN_AW), .OFF('0)) u_dec_scan (
        .addr(scan_addr), .idx(s_idx), .aligned(s_al)
    );

    cfgrf_addr_decode #(.AW(MM_AW), .OFF(MM_IDX_OFF)) u_dec_mm (
        .addr(mm_addr), .idx(m_idx), .aligned(m_al)
    );

    // Select the single access served this cycle; scan has priority.
    always_comb begin
        mm_blocked = mm_valid && scan_valid;
        acc_valid  = scan_valid || mm_valid;
        acc_mm     = !scan_valid;
        acc_idx    = acc_mm ? m_idx      : s_idx;
        acc_al     = acc_mm ? m_al       : s_al;
        acc_write  = acc_mm ? mm_write   : scan_write;
        acc_wdata  = acc_mm ? mm_wdata   : scan_wdata;
    end

    // Legality of the served access and the error condition.
    always_comb begin
        ok_rd   = acc_al && rd_hit;
        ok_wr   = acc_al && wr_legal(acc_idx, acc_mm);
        wr_en   = acc_valid && acc_write && ok_wr;
        err_d   = (acc_valid && !(acc_write ? ok_wr : ok_rd)) || mm_blocked;
        rd_word = ok_rd ? rd_data : '1;
    end

    cfgrf_store #(
        .NUM_SRC(NUM_SRC), .BAR_MASK(BAR_MASK), .BAR_RESET(BAR_RESET)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(acc_idx), .wr_data(acc_wdata),
        .irq_lvl(irq_lvl),
        .fault_q(fault_q), .ctrl_q(ctrl_q), .base_q(base_q),
        .sbase_q(sbase_q), .stat_q(stat_q), .plain_q(plain_q),
        .win_chg(win_changed)
    );

    cfgrf_read_mux u_rmux (
        .idx(acc_idx),
        .fault_q(fault_q), .ctrl_q(ctrl_q), .base_q(base_q),
        .sbase_q(sbase_q), .stat_q(stat_q), .plain_q(plain_q),
        .rd_data(rd_data), .rd_hit(rd_hit)
    );

    // Scan port read response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_rvalid <= 1'b0;
            scan_rdata  <= '0;
        end else begin
            scan_rvalid <= scan_valid && !scan_write;
            if (scan_valid && !scan_write) scan_rdata <= rd_word;
        end
    end

    // Memory-mapped port read response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_rvalid <= 1'b0;
            mm_rdata  <= '0;
        end else begin
            mm_rvalid <= mm_valid && !mm_write;
            if (mm_valid && !mm_write) mm_rdata <= mm_blocked ? '1 : rd_word;
        end
    end

    // Shared error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= err_d;
    end

    // Window outputs for the external remapper.
    always_comb begin
        win_base = base_q & BAR_MASK;
        win_en   = base_q[0];
    end

endmodule

// File: rtl/dual_path_cfg_regs_chk.sv
// Checker: temporal properties on the ports of dual_path_cfg_regs.
// Assumes single-cycle requests and reset held for at least two clocks.
module dual_path_cfg_regs_chk #(
    parameter int SCAN_AW = 8,
    parameter int MM_AW   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scan_valid,
    input logic               scan_write,
    input logic [SCAN_AW-1:0] scan_addr,
    input logic               mm_valid,
    input logic               mm_write,
    input logic [MM_AW-1:0]   mm_addr,
    input logic               scan_rvalid,
    input logic               mm_rvalid,
    input logic               err_pulse,
    input logic               win_changed,
    input logic [63:0]        win_base,
    input logic               win_en
);

    AST_SCAN_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        scan_rvalid |-> $past(scan_valid && !scan_write)); // R9

    AST_MM_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rvalid |-> $past(mm_valid && !mm_write)); // R9

    AST_MISALIGNED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_addr[2:0] != 3'b000) |=> err_pulse); // R2

    AST_MM_BASE_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_valid && mm_write && mm_addr == '0) |=> (err_pulse && $stable(win_base) && $stable(win_en))); // R5

    AST_WIN_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_changed |-> (win_base != $past(win_base) || win_en != $past(win_en))); // R10

    AST_BASE_ONLY_BY_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base != $past(win_base)) |-> $past(scan_valid && scan_write)); // R5

    AST_COLLISION_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && mm_valid) |=> err_pulse); // R11

endmodule

bind dual_path_cfg_regs dual_path_cfg_regs_chk #(.SCAN_AW(SCAN_AW), .MM_AW(MM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .scan_valid(scan_valid), .scan_write(scan_write), .scan_addr(scan_addr),
    .mm_valid(mm_valid), .mm_write(mm_write), .mm_addr(mm_addr),
    .scan_rvalid(scan_rvalid), .mm_rvalid(mm_rvalid),
    .err_pulse(err_pulse), .win_changed(win_changed),
    .win_base(win_base), .win_en(win_en)
);

// File: tb/dual_path_cfg_regs_tb.sv
// Scoreboard bench: driver tasks queue expectations, a monitor checks them
// one cycle after each request is sampled.
module dual_path_cfg_regs_tb;

    localparam logic [63:0] MASK  = 64'h0003_ffff_fff0_0000;
    localparam logic [63:0] RSTV  = 64'h0000_0006_0300_0000;
    localparam logic [63:0] BASE0 = (RSTV & MASK) | 64'h1;
    localparam logic [63:0] ONES  = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_valid = 1'b0, scan_write = 1'b0;
    logic [7:0]  scan_addr = '0;
    logic [63:0] scan_wdata = '0;
    logic        scan_rvalid;
    logic [63:0] scan_rdata;
    logic        mm_valid = 1'b0, mm_write = 1'b0;
    logic [7:0]  mm_addr = '0;
    logic [63:0] mm_wdata = '0;
    logic        mm_rvalid;
    logic [63:0] mm_rdata;
    logic [4:0]  irq_lvl = '0;
    logic        err_pulse, win_changed, win_en;
    logic [63:0] win_base;

    always #2 clk = ~clk;

    dual_path_cfg_regs #(.BAR_MASK(MASK), .BAR_RESET(RSTV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .scan_valid(scan_valid), .scan_write(scan_write), .scan_addr(scan_addr),
        .scan_wdata(scan_wdata), .scan_rvalid(scan_rvalid), .scan_rdata(scan_rdata),
        .mm_valid(mm_valid), .mm_write(mm_write), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata),
        .irq_lvl(irq_lvl), .err_pulse(err_pulse), .win_changed(win_changed),
        .win_base(win_base), .win_en(win_en)
    );

    typedef struct {
        bit          is_mm;
        bit          is_rd;
        logic [63:0] data;
        bit          err;
        bit          win;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: compares responses due this cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc + 1 == cyc) begin
            exp_t e;
            logic rv;
            logic [63:0] rd;
            e  = exp_q.pop_front();
            rv = e.is_mm ? mm_rvalid : scan_rvalid;
            rd = e.is_mm ? mm_rdata : scan_rdata;
            check(rv == e.is_rd, {e.tag, " rvalid"}, 64'(rv), 64'(e.is_rd));
            if (e.is_rd) check(rd == e.data, {e.tag, " rdata"}, rd, e.data);
            check(err_pulse == e.err, {e.tag, " err"}, 64'(err_pulse), 64'(e.err));
            check(win_changed == e.win, {e.tag, " win_changed"}, 64'(win_changed), 64'(e.win));
        end
    end

    task automatic sync();
        @(posedge clk);
        #1;
        scan_valid = 1'b0;
        mm_valid   = 1'b0;
    endtask

    task automatic push(input bit is_mm, input bit is_rd, input logic [63:0] d,
                        input bit err, input bit win, input string tag);
        exp_t e;
        e.is_mm = is_mm; e.is_rd = is_rd; e.data = d; e.err = err;
        e.win = win; e.cyc = cyc; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic put_scan(input bit wr, input logic [7:0] a, input logic [63:0] d,
                            input logic [63:0] expd, input bit err, input bit win, input string tag);
        scan_valid = 1'b1; scan_write = wr; scan_addr = a; scan_wdata = d;
        push(1'b0, !wr, expd, err, win, tag);
    endtask

    task automatic put_mm(input bit wr, input logic [7:0] a, input logic [63:0] d,
                          input logic [63:0] expd, input bit err, input bit win, input string tag);
        mm_valid = 1'b1; mm_write = wr; mm_addr = a; mm_wdata = d;
        push(1'b1, !wr, expd, err, win, tag);
    endtask

    task automatic s_wr(input logic [7:0] a, input logic [63:0] d, input bit err, input bit win, input string tag);
        sync(); put_scan(1'b1, a, d, '0, err, win, tag);
    endtask
    task automatic s_rd(input logic [7:0] a, input logic [63:0] expd, input bit err, input string tag);
        sync(); put_scan(1'b0, a, '0, expd, err, 1'b0, tag);
    endtask
    task automatic m_wr(input logic [7:0] a, input logic [63:0] d, input bit err, input string tag);
        sync(); put_mm(1'b1, a, d, '0, err, 1'b0, tag);
    endtask
    task automatic m_rd(input logic [7:0] a, input logic [63:0] expd, input bit err, input string tag);
        sync(); put_mm(1'b0, a, '0, expd, err, 1'b0, tag);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [63:0] fault_m, ctrl_m;
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state at the ports
        check(win_en == 1'b1, "R1 win_en", 64'(win_en), 64'h1);
        check(win_base == (BASE0 & MASK), "R1 win_base", win_base, BASE0 & MASK);
        check(err_pulse == 1'b0 && scan_rvalid == 1'b0 && mm_rvalid == 1'b0,
              "R1 strobes", 64'(err_pulse), 64'h0);
        rst_n = 1'b1;
        s_rd(8'h50, BASE0, 1'b0, "R1 R2 scan base reset");
        m_rd(8'h00, BASE0, 1'b0, "R1 R2 mm base reset");
        s_rd(8'h00, '0, 1'b0, "R1 fault reset");
        m_rd(8'h20, '0, 1'b0, "R1 R2 ctrl reset via mm");
        s_rd(8'h58, '0, 1'b0, "R1 sbase reset");

        // R3: fault register aliases
        fault_m = 64'hF0F0_1234_5678_9ABC;
        s_wr(8'h00, fault_m, 1'b0, 1'b0, "R3 fault direct");
        s_rd(8'h00, fault_m, 1'b0, "R3 fault readback");
        s_wr(8'h08, 64'hFF00_FF00_FF00_FF00, 1'b0, 1'b0, "R3 fault and");
        fault_m = fault_m & 64'hFF00_FF00_FF00_FF00;
        s_rd(8'h00, fault_m, 1'b0, "R3 fault after and");
        m_wr(8'h00, 64'h0, 1'b1, "R5 mm base write refused");
        s_wr(8'h10, 64'h0000_0000_0000_000F, 1'b0, 1'b0, "R3 fault or");
        fault_m = fault_m | 64'hF;
        s_rd(8'h00, fault_m, 1'b0, "R3 fault after or");
        s_rd(8'h50, BASE0, 1'b0, "R5 base unchanged after mm write");

        // R4: control register aliases
        ctrl_m = 64'h8400_0000_0000_1111;
        s_wr(8'h70, ctrl_m, 1'b0, 1'b0, "R4 ctrl direct");
        s_wr(8'h90, 64'h0000_2000_0000_00F0, 1'b0, 1'b0, "R4 ctrl set");
        ctrl_m = ctrl_m | 64'h0000_2000_0000_00F0;
        m_rd(8'h20, ctrl_m, 1'b0, "R4 ctrl after set");
        s_wr(8'h98, 64'h8000_0000_0000_0011, 1'b0, 1'b0, "R4 ctrl clear");
        ctrl_m = ctrl_m & ~64'h8000_0000_0000_0011;
        s_rd(8'h70, ctrl_m, 1'b0, "R4 ctrl after clear");
        m_wr(8'h40, 64'h0000_0000_0000_0100, 1'b0, "R4 ctrl set via mm");
        ctrl_m = ctrl_m | 64'h100;
        s_rd(8'h70, ctrl_m, 1'b0, "R4 ctrl after mm set");

        // R5 R10: base register masking and change strobe
        s_wr(8'h50, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, "R5 R10 base write changes");
        s_rd(8'h50, MASK, 1'b0, "R5 base masked");
        sync();
        check(win_en == 1'b0 && win_base == MASK, "R5 window outputs", win_base, MASK);
        s_wr(8'h50, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0, "R10 same value no pulse");
        s_wr(8'h50, 64'h1, 1'b0, 1'b1, "R10 enable only");
        s_rd(8'h50, 64'h1, 1'b0, "R5 base enable only");

        // R6: secondary base keeps bits 49..32
        s_wr(8'h58, ONES, 1'b0, 1'b0, "R6 sbase write");
        m_rd(8'h08, 64'h0003_ffff_0000_0000, 1'b0, "R6 sbase masked");

        // R7: unimplemented and write-only indices
        s_rd(8'h18, ONES, 1'b1, "R7 read unimplemented");
        s_wr(8'h18, 64'h5, 1'b1, 1'b0, "R7 write unimplemented");
        s_rd(8'hF8, ONES, 1'b1, "R7 read high index");
        m_rd(8'hF8, ONES, 1'b1, "R7 mm read beyond range");
        s_rd(8'h08, ONES, 1'b1, "R7 read and alias");
        s_rd(8'h90, ONES, 1'b1, "R7 read set alias");
        s_rd(8'h00, fault_m, 1'b0, "R7 fault untouched");

        // R8: status register
        irq_lvl = 5'b10101;
        sync();
        s_rd(8'hA8, 64'h15, 1'b0, "R8 status mirror");
        s_wr(8'hA8, ONES, 1'b1, 1'b0, "R8 status write refused");
        s_rd(8'hA8, 64'h15, 1'b0, "R8 status unchanged");
        irq_lvl = 5'b01010;
        sync();
        m_rd(8'h58, 64'h0A, 1'b0, "R8 R2 status via mm");

        // R12: plain registers
        s_wr(8'h30, 64'h1111_2222_3333_4444, 1'b0, 1'b0, "R12 plain 06");
        s_wr(8'h38, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 1'b0, "R12 plain 07");
        m_wr(8'h28, 64'h0123_4567_89AB_CDEF, 1'b0, "R12 plain 0F via mm");
        m_wr(8'h50, 64'hFEDC_BA98_7654_3210, 1'b0, "R12 plain 14 via mm");
        s_rd(8'h30, 64'h1111_2222_3333_4444, 1'b0, "R12 plain 06 read");
        s_rd(8'h38, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, "R12 plain 07 read");
        s_rd(8'h78, 64'h0123_4567_89AB_CDEF, 1'b0, "R12 plain 0F read");
        m_rd(8'h50, 64'hFEDC_BA98_7654_3210, 1'b0, "R12 plain 14 read");

        // R2: misaligned accesses
        s_wr(8'h04, ONES, 1'b1, 1'b0, "R2 misaligned scan write");
        s_rd(8'h00, fault_m, 1'b0, "R2 fault untouched by misaligned");
        m_rd(8'h21, ONES, 1'b1, "R2 misaligned mm read");

        // R11: collisions
        sync();
        put_scan(1'b0, 8'h70, '0, ctrl_m, 1'b1, 1'b0, "R11 scan served in collision");
        put_mm(1'b1, 8'h20, 64'h0, '0, 1'b1, 1'b0, "R11 mm write refused");
        s_rd(8'h70, ctrl_m, 1'b0, "R11 ctrl unchanged");
        sync();
        put_scan(1'b1, 8'h00, 64'h77, '0, 1'b1, 1'b0, "R11 scan write in collision");
        put_mm(1'b0, 8'h20, '0, ONES, 1'b1, 1'b0, "R11 mm read refused");
        s_rd(8'h00, 64'h77, 1'b0, "R11 scan write took effect");

        // R9: strobe lasts one cycle
        s_rd(8'h18, ONES, 1'b1, "R9 error pulse");
        s_rd(8'h00, 64'h77, 1'b0, "R9 error cleared next cycle");

        repeat (3) sync();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule